// File: doc/BRIEF.md
# Boost Overvoltage Fault Supervisor

This block sits between the digitised protection comparators of a dual-string LED boost driver and the power stage enables. Once per switching cycle a strobe marks the moment the comparator flags are valid. The block counts how many strobes in a row each overvoltage flag stays high. Once a flag has persisted long enough, it decides how the boost switch and the two current sinks react. The reaction depends on the state of the other string. If the other string is unused, the fault is latched with the sinks kept running. If the other string has collapsed below 0.5 V, the fault is latched and that string's sink is dropped. If neither applies, the event is a transient, and switching resumes once the pin falls below its hysteresis level.

A switch-node overvoltage that persists is always a latch-off fault. A latched fault is held until a restart request arrives. The restart request stands for power-on reset or a toggle of either enable input. Over-temperature forces every output off at once without touching the latch, and the block releases when the flag drops. The flag's hysteresis is applied upstream. All control and status pins are plain level signals. The block has no data stream and no handshake.

Top module: `ovp_fault_supervisor`

## Requirements
- R1: After reset, with no flags set, `boost_en` is 1, `latched_off` is 0 and `sink_en[i]` equals the inverse of `ch_unused[i]`.
- R2: When `sw_ovp` is high on SW_QUAL (24) consecutive strobes, `latched_off` goes to 1 and `boost_en` goes to 0 at that 24th strobe edge, and all sinks turn off. At 23 strobes nothing changes.
- R3: A strobe with the qualifying flag low clears that flag's persistence count, so the count starts again from zero.
- R4: A latched fault stays until `restart_req` is high on a clock edge. That edge clears the latch, every sink drop, every transient hold and every count.
- R5: When `fb_ovp[i]` is high on FB_QUAL (28) consecutive strobes and every other channel is unused, the block latches off with `boost_en` at 0 and channel i's sink still enabled. This case takes precedence over R6.
- R6: When `fb_ovp[i]` qualifies and another used channel has `fb_low` set, the block latches off with `boost_en` at 0. The sink of each such low channel is disabled, and channel i's sink stays enabled.
- R7: When `fb_ovp[i]` qualifies and neither R5 nor R6 applies, `boost_en` goes to 0 and `latched_off` stays 0. `boost_en` returns to 1 after the first strobe on which `fb_hyst_clr[i]` is high.
- R8: While `over_temp` is high, `boost_en` and every `sink_en` are 0 in the same cycle, and `latched_off` keeps its value. When `over_temp` falls, the outputs return to what the fault state dictates.
- R9: An unused channel's sink is never enabled, and its `fb_ovp` flag is never counted.
- R10: Persistence counts advance only on cycles with `cyc_stb` high and `over_temp` low. Flags seen on other cycles neither count nor clear a count, and no latch can set without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_stb | input | 1 | One-cycle strobe per switching cycle; the flags are sampled here |
| sw_ovp | input | 1 | Switch-node overvoltage comparator flag |
| fb_ovp | input | NUM_CH | Per-channel feedback-pin overvoltage flag |
| fb_low | input | NUM_CH | Per-channel feedback pin below 0.5 V |
| fb_hyst_clr | input | NUM_CH | Per-channel feedback pin back below its hysteresis level |
| ch_unused | input | NUM_CH | Per-channel string unused (pin tied to ground) |
| over_temp | input | 1 | Over-temperature flag, with its hysteresis applied upstream |
| restart_req | input | 1 | Clears a latched fault (power-on or enable toggle) |
| boost_en | output | 1 | Boost switching permitted |
| sink_en | output | NUM_CH | Per-channel current sink enable |
| latched_off | output | 1 | A latch-off fault is held |

## Verification
The fault state is held in a latch bit, a per-channel sink-drop mask and a per-channel transient hold. Every one of them reaches the ports through the enables with no register in between. A wrong latch or hold therefore shows on `boost_en` or `latched_off` at the very strobe edge that qualifies the fault, and a wrong drop mask shows on `sink_en` at that same edge. A persistence counter that is off by one moves the qualifying edge by one strobe. The bench probes one strobe before the threshold and the threshold itself to catch that. A counter that fails to clear shows only after a broken run followed by a fresh run one strobe short of the threshold.

// File: rtl/ovp_pkg.sv
package ovp_pkg;
  typedef enum logic [1:0] {
    RESP_KEEP_SINKS = 2'd0,
    RESP_DROP_PEER  = 2'd1,
    RESP_TRANSIENT  = 2'd2
  } fb_resp_e;
endpackage

// File: rtl/ovp_persist_cnt.sv
module ovp_persist_cnt #(
  parameter int QUAL = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cnt_en,
  input  logic flag,
  output logic hit
);
  localparam int W = $clog2(QUAL + 1);
  localparam logic [W-1:0] LAST = W'(QUAL - 1);
  localparam logic [W-1:0] SAT  = W'(QUAL);

  logic [W-1:0] cnt_q;

  assign hit = cnt_en & flag & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      if (!flag) begin
        cnt_q <= '0;
      end else if (cnt_q != SAT) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ovp_fb_channel.sv
module ovp_fb_channel
  import ovp_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int IDX     = 0,
  parameter int FB_QUAL = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cnt_en,
  input  logic              fb_ovp_i,
  input  logic [NUM_CH-1:0] ch_unused,
  input  logic [NUM_CH-1:0] fb_low,
  output logic              hit,
  output fb_resp_e          resp,
  output logic [NUM_CH-1:0] drop_mask
);
  logic peers_unused;

  ovp_persist_cnt #(.QUAL(FB_QUAL)) cnt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .cnt_en (cnt_en),
    .flag   (fb_ovp_i & ~ch_unused[IDX]),
    .hit    (hit)
  );

  always_comb begin
    peers_unused = 1'b1;
    drop_mask    = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (k != IDX && !ch_unused[k]) begin
        peers_unused = 1'b0;
        drop_mask[k] = fb_low[k];
      end
    end
    if (peers_unused)    resp = RESP_KEEP_SINKS;
    else if (|drop_mask) resp = RESP_DROP_PEER;
    else                 resp = RESP_TRANSIENT;
  end
endmodule

// File: rtl/ovp_fault_supervisor.sv
module ovp_fault_supervisor
  import ovp_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int SW_QUAL = 24,
  parameter int FB_QUAL = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_stb,
  input  logic              sw_ovp,
  input  logic [NUM_CH-1:0] fb_ovp,
  input  logic [NUM_CH-1:0] fb_low,
  input  logic [NUM_CH-1:0] fb_hyst_clr,
  input  logic [NUM_CH-1:0] ch_unused,
  input  logic              over_temp,
  input  logic              restart_req,
  output logic              boost_en,
  output logic [NUM_CH-1:0] sink_en,
  output logic              latched_off
);
  logic              cnt_en;
  logic              sw_hit;
  logic [NUM_CH-1:0] fb_hit;
  fb_resp_e          fb_resp   [NUM_CH];
  logic [NUM_CH-1:0] drop_mask [NUM_CH];

  logic              latch_q, latch_d;
  logic [NUM_CH-1:0] kill_q, kill_d;
  logic [NUM_CH-1:0] hold_q, hold_d;

  assign cnt_en = cyc_stb & ~over_temp;

  ovp_persist_cnt #(.QUAL(SW_QUAL)) sw_cnt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (restart_req),
    .cnt_en (cnt_en),
    .flag   (sw_ovp),
    .hit    (sw_hit)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ovp_fb_channel #(.NUM_CH(NUM_CH), .IDX(g), .FB_QUAL(FB_QUAL)) ch_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (restart_req),
      .cnt_en    (cnt_en),
      .fb_ovp_i  (fb_ovp[g]),
      .ch_unused (ch_unused),
      .fb_low    (fb_low),
      .hit       (fb_hit[g]),
      .resp      (fb_resp[g]),
      .drop_mask (drop_mask[g])
    );
  end

  always_comb begin
    latch_d = latch_q;
    kill_d  = kill_q;
    hold_d  = hold_q;
    if (restart_req) begin
      latch_d = 1'b0;
      kill_d  = '0;
      hold_d  = '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (cnt_en && fb_hyst_clr[i] && !fb_hit[i]) hold_d[i] = 1'b0;
        if (fb_hit[i]) begin
          case (fb_resp[i])
            RESP_KEEP_SINKS: latch_d = 1'b1;
            RESP_DROP_PEER: begin
              latch_d = 1'b1;
              kill_d  = kill_d | drop_mask[i];
            end
            default: hold_d[i] = 1'b1;
          endcase
        end
      end
      if (sw_hit) begin
        latch_d = 1'b1;
        kill_d  = '1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      kill_q  <= '0;
      hold_q  <= '0;
    end else begin
      latch_q <= latch_d;
      kill_q  <= kill_d;
      hold_q  <= hold_d;
    end
  end

  assign latched_off = latch_q;
  assign boost_en    = ~over_temp & ~latch_q & ~(|hold_q);
  assign sink_en     = {NUM_CH{~over_temp}} & ~ch_unused & ~kill_q;
endmodule

// File: rtl/ovp_fault_supervisor_chk.sv
module ovp_fault_supervisor_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_stb,
  input logic [NUM_CH-1:0] ch_unused,
  input logic              over_temp,
  input logic              restart_req,
  input logic              boost_en,
  input logic [NUM_CH-1:0] sink_en,
  input logic              latched_off
);
  assert_latch_stops_boost_R2: assert property (@(posedge clk) disable iff (!rst_n)
    latched_off |-> !boost_en);

  assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !latched_off);

  assert_latch_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_off && !restart_req) |=> latched_off);

  assert_thermal_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    over_temp |-> (!boost_en && sink_en == '0));

  assert_unused_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_en & ch_unused) == '0);

  assert_no_strobe_no_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_stb && !latched_off) |=> !latched_off);
endmodule

bind ovp_fault_supervisor ovp_fault_supervisor_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cyc_stb     (cyc_stb),
  .ch_unused   (ch_unused),
  .over_temp   (over_temp),
  .restart_req (restart_req),
  .boost_en    (boost_en),
  .sink_en     (sink_en),
  .latched_off (latched_off)
);

// File: tb/ovp_fault_supervisor_tb.sv
`timescale 1ns/1ps
module ovp_fault_supervisor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_stb = 1'b0;
  logic       sw_ovp = 1'b0;
  logic [1:0] fb_ovp = '0;
  logic [1:0] fb_low = '0;
  logic [1:0] fb_hyst_clr = '0;
  logic [1:0] ch_unused = '0;
  logic       over_temp = 1'b0;
  logic       restart_req = 1'b0;
  logic       boost_en;
  logic [1:0] sink_en;
  logic       latched_off;

  int  n_tests = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  ovp_fault_supervisor #(.NUM_CH(2), .SW_QUAL(24), .FB_QUAL(28)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .sw_ovp(sw_ovp),
    .fb_ovp(fb_ovp), .fb_low(fb_low), .fb_hyst_clr(fb_hyst_clr),
    .ch_unused(ch_unused), .over_temp(over_temp), .restart_req(restart_req),
    .boost_en(boost_en), .sink_en(sink_en), .latched_off(latched_off)
  );

  // observed vector: {latched_off, boost_en, sink_en[1:0]}
  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] got;
    got = {latched_off, boost_en, sink_en};
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic strobes(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cyc_stb = 1'b1;
    end
    @(negedge clk);
    cyc_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic restart();
    @(negedge clk);
    sw_ovp = 0; fb_ovp = '0; fb_low = '0; fb_hyst_clr = '0;
    ch_unused = '0; over_temp = 0;
    restart_req = 1'b1;
    @(negedge clk);
    restart_req = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset state", 4'b0111);
  endtask

  task automatic t_sw_latch();
    sw_ovp = 1; strobes(23);
    check("R2 sw ovp 23 strobes no latch", 4'b0111);
    sw_ovp = 0; strobes(1);
    sw_ovp = 1; strobes(23);
    check("R3 count cleared by low strobe", 4'b0111);
    strobes(1);
    check("R2 sw ovp 24 strobes latch", 4'b1000);
  endtask

  task automatic t_latch_hold();
    sw_ovp = 0; strobes(5); idle(3);
    check("R4 latch held without restart", 4'b1000);
    restart();
    check("R4 restart clears latch", 4'b0111);
  endtask

  task automatic t_fb_unused_peer();
    ch_unused = 2'b10; fb_ovp = 2'b01;
    strobes(27);
    check("R5 fb ovp 27 strobes no action", 4'b0101);
    strobes(1);
    check("R5 peer unused latch keeps sink", 4'b1001);
    restart();
    // unused peer wins over low peer
    ch_unused = 2'b10; fb_low = 2'b10; fb_ovp = 2'b01;
    strobes(28);
    check("R5 unused precedence over low", 4'b1001);
    restart();
  endtask

  task automatic t_fb_low_peer();
    fb_low = 2'b10; fb_ovp = 2'b01;
    strobes(28);
    check("R6 low peer dropped, latched", 4'b1001);
    restart();
    check("R6 restart restores both sinks", 4'b0111);
  endtask

  task automatic t_fb_transient();
    fb_ovp = 2'b10;
    strobes(28);
    check("R7 transient stops boost, no latch", 4'b0011);
    fb_ovp = 2'b00; strobes(2);
    check("R7 held until hysteresis clear", 4'b0011);
    fb_hyst_clr = 2'b10; strobes(1); fb_hyst_clr = 2'b00;
    check("R7 resumes after hysteresis clear", 4'b0111);
  endtask

  task automatic t_thermal();
    @(negedge clk); over_temp = 1;
    @(negedge clk);
    check("R8 thermal forces all off", 4'b0000);
    sw_ovp = 1; strobes(30);
    check("R10 no count during thermal", 4'b0000);
    sw_ovp = 0; over_temp = 0; @(negedge clk);
    check("R8 release after thermal", 4'b0111);
    sw_ovp = 1; strobes(24); sw_ovp = 0;
    over_temp = 1; @(negedge clk);
    check("R8 thermal keeps latch bit", 4'b1000);
    over_temp = 0; @(negedge clk);
    check("R8 latch remains after thermal", 4'b1000);
    restart();
  endtask

  task automatic t_no_strobe();
    sw_ovp = 1; idle(40);
    check("R10 no strobe no count", 4'b0111);
    strobes(20); sw_ovp = 1; idle(10); strobes(4);
    check("R10 gaps do not clear count", 4'b1000);
    restart();
  endtask

  task automatic t_unused();
    ch_unused = 2'b01; @(negedge clk);
    check("R9 unused sink off", 4'b0110);
    fb_ovp = 2'b01; strobes(30);
    check("R9 unused fb ovp ignored", 4'b0110);
    restart();
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_sw_latch();
    t_latch_hold();
    t_fb_unused_peer();
    t_fb_low_peer();
    t_fb_transient();
    t_thermal();
    t_no_strobe();
    t_unused();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule